// File: doc/BRIEF.md
# SPI EEPROM transfer controller

This block lets a host bus move a short burst of bytes to or from a serial EEPROM. The host sets a word address and a byte count through a small register file. It can preload a data buffer that the host also accesses directly. It then starts the transfer by writing either the read-command register or the write-command register. The block runs the SPI frames by itself and reports progress and failures in a read-only status register, which the host polls.

When a command arrives, three conditions are checked at that moment: the byte count is not zero, the interface-enable input is high, and the device-ready acknowledge input is high. If any of them fails, the request is dropped with no SPI traffic. Every failing check raises its own flag. On a read, the block opens one chip-select frame, sends the read opcode and a 16-bit byte address, and captures the returned bytes into the buffer. On a write, it first sends a single write-enable opcode in a frame of its own, releases chip select, and then sends the write opcode, the address and the buffered bytes. The byte address is always twice the word address, so each word address selects a 16-bit EEPROM word.

Top module: `eep_xfer_ctl`

## Requirements
- R1: The status register at offset 0x1F reads 0x00 after reset. Its bit 3 is the zero-count error, bit 2 the acknowledge error, bit 1 the interface-enable error, bit 0 busy, and bits 7..4 always read 0.
- R2: Offset 0x28 holds the 8-bit word address (read/write). Offset 0x29 holds the byte count in its low CNT_W bits, and its upper bits read 0. Offsets 0x40 + i, for i < 2**CNT_W, read and write buffer byte i. A write of any value to offset 0x2A starts a read, and to offset 0x2B starts a write.
- R3: Busy reads 1 on the first poll after an accepted command write, in the cycle that follows it.
- R4: An accepted command write replaces all three error flags in the next cycle. Flags whose check passed read 0.
- R5: A byte count of zero at command time sets bit 3. No chip-select activity follows.
- R6: A low interface-enable input at command time sets bit 1, and a low acknowledge input sets bit 2. In either case there is no SPI traffic. Errors that occur together are flagged together. Busy reads 1 for exactly one cycle and then 0, with the flags already final.
- R7: While busy is 1, host writes to the address register, the count register, the buffer and both command registers have no effect.
- R8: A read runs one chip-select-low frame. The frame carries 0x03, then {7'b0, word[7]}, then {word[6:0], 1'b0}, then count data bytes. Byte k returned on the data line lands in buffer entry k.
- R9: A write runs a frame carrying only 0x06. Chip select then goes high, and a second frame carries 0x02, the two address bytes as in R8, and buffer entries 0..count-1 in order.
- R10: SPI uses mode 0 with the most significant bit first. The serial clock stays low whenever chip select is high, and the data-out line does not change while the serial clock is high.
- R11: Busy returns to 0 only after chip select has risen at the end of the last frame. After a successful operation the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host register offset |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| if_en | input | 1 | Interface-enable check input, sampled at command time |
| dev_ack | input | 1 | Device-ready acknowledge check input, sampled at command time |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |

## Verification
The bench builds the block with CNT_W = 3, HALF = 2 and GAP = 3. The buffer is then 8 entries deep, so every legal byte count from 1 to 7 can be swept for both reads and writes at several word addresses, including 0x00, 0x7F, 0x80 and 0xFF, where the upper address byte changes. The small count width also makes the register's truncation and its zero value easy to reach. All seven combinations of the three start-time failures are driven, and each one's flag pattern and single-cycle busy pulse are checked.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OFS_STATUS = 8'h1F;
  localparam logic [7:0] OFS_WADDR  = 8'h28;
  localparam logic [7:0] OFS_COUNT  = 8'h29;
  localparam logic [7:0] OFS_GO_RD  = 8'h2A;
  localparam logic [7:0] OFS_GO_WR  = 8'h2B;
  localparam logic [7:0] OFS_BUF    = 8'h40;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WREN, SQ_GAP, SQ_INSTR, SQ_AHI, SQ_ALO, SQ_DATA, SQ_TAIL
  } seq_t;

  typedef struct packed {
    logic cnt_zero;
    logic no_ack;
    logic no_if;
  } chk_t;

  function automatic logic [15:0] word_to_byte(input logic [7:0] w);
    return {7'd0, w, 1'b0};
  endfunction

  function automatic logic [7:0] pack_status(input chk_t e, input logic busy);
    return {4'd0, e.cnt_zero, e.no_ack, e.no_if, busy};
  endfunction
endpackage

// File: rtl/eep_hostregs.sv
module eep_hostregs
  import eep_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       host_addr,
  input  logic             host_we,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             if_en,
  input  logic             dev_ack,
  input  logic             seq_done,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [CNT_W-1:0] buf_idx,
  output logic [7:0]       waddr_q,
  output logic [CNT_W-1:0] count_q,
  output logic             busy,
  output logic             ev_accept,
  output chk_t             ev_chk,
  output logic             launch,
  output logic             launch_wr
);
  chk_t errs;
  logic reject_q;
  logic in_win;
  logic wr_ok;

  assign wr_ok     = host_we && !busy;
  assign in_win    = (host_addr[7:CNT_W] == OFS_BUF[7:CNT_W]);
  assign buf_idx   = host_addr[CNT_W-1:0];
  assign buf_we    = wr_ok && in_win;
  assign ev_accept = wr_ok && (host_addr == OFS_GO_RD || host_addr == OFS_GO_WR);

  assign ev_chk.cnt_zero = (count_q == '0);
  assign ev_chk.no_ack   = !dev_ack;
  assign ev_chk.no_if    = !if_en;

  assign launch    = ev_accept && (ev_chk == '0);
  assign launch_wr = launch && (host_addr == OFS_GO_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      errs     <= '0;
      reject_q <= 1'b0;
      waddr_q  <= '0;
      count_q  <= '0;
    end else begin
      reject_q <= ev_accept && (ev_chk != '0);
      if (ev_accept) begin
        busy <= 1'b1;
        errs <= ev_chk;
      end else if (reject_q || seq_done) begin
        busy <= 1'b0;
      end
      if (wr_ok && host_addr == OFS_WADDR) waddr_q <= host_wdata;
      if (wr_ok && host_addr == OFS_COUNT) count_q <= host_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (in_win) host_rdata = buf_rdata;
    else begin
      case (host_addr)
        OFS_STATUS: host_rdata = pack_status(errs, busy);
        OFS_WADDR:  host_rdata = waddr_q;
        OFS_COUNT:  host_rdata = 8'(count_q);
        default:    host_rdata = 8'h00;
      endcase
    end
  end

  // R3: busy reads 1 on the first poll after an accepted command
  a_r3_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);
  // R4: a clean start leaves all error flags clear
  a_r4_errs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_chk == '0) |=> (errs == '0));
  // R7: address register frozen while busy
  a_r7_waddr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_addr == OFS_WADDR) |=> $stable(waddr_q));
  // R7: count register frozen while busy
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_addr == OFS_COUNT) |=> $stable(count_q));
endmodule

// File: rtl/eep_buf.sv
module eep_buf #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we,
  input  logic [CNT_W-1:0] h_idx,
  input  logic [7:0]       h_wdata,
  output logic [7:0]       h_rdata,
  input  logic             e_we,
  input  logic [CNT_W-1:0] e_widx,
  input  logic [7:0]       e_wdata,
  input  logic [CNT_W-1:0] e_ridx,
  output logic [7:0]       e_rdata
);
  localparam int DEPTH = 1 << CNT_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= 8'h00;
      else if (h_we && h_idx == CNT_W'(g)) mem[g] <= h_wdata;
      else if (e_we && e_widx == CNT_W'(g)) mem[g] <= e_wdata;
    end
  end

  assign h_rdata = mem[h_idx];
  assign e_rdata = mem[e_ridx];
endmodule

// File: rtl/eep_spi_byte.sv
module eep_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic            active;
  logic [2:0]      bitn;
  logic [HC_W-1:0] hcnt;
  logic [7:0]      sh;
  logic            half_end;

  assign half_end = (hcnt == HC_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bitn   <= '0;
      hcnt   <= '0;
      sh     <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sh     <= tx;
          mosi   <= tx[7];
          sck    <= 1'b0;
          hcnt   <= '0;
          bitn   <= '0;
        end
      end else if (half_end) begin
        hcnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        hcnt <= hcnt + HC_W'(1);
      end
    end
  end

  // R10: data-out holds steady through a high clock phase
  a_r10_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/eep_xfer_ctl.sv
module eep_xfer_ctl
  import eep_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int HALF  = 2,
  parameter int GAP   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_addr,
  input  logic       host_we,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       if_en,
  input  logic       dev_ack,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;

  logic             busy, ev_accept, launch, launch_wr, seq_done;
  chk_t             ev_chk;
  logic [7:0]       waddr_q;
  logic [CNT_W-1:0] count_q;
  logic             hb_we;
  logic [CNT_W-1:0] hb_idx;
  logic [7:0]       hb_rdata;

  logic             e_we;
  logic [CNT_W-1:0] e_ridx;
  logic [7:0]       e_rdata;

  seq_t             st;
  logic             wr_lat;
  logic [CNT_W-1:0] cnt_lat, idx;
  logic [15:0]      addr_lat;
  logic [GW-1:0]    gap;
  logic             go_q, cs_q;
  logic [7:0]       tx_q;
  logic             bdone;
  logic [7:0]       brx;
  logic             last;

  eep_hostregs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .if_en(if_en), .dev_ack(dev_ack),
    .seq_done(seq_done), .buf_rdata(hb_rdata), .buf_we(hb_we), .buf_idx(hb_idx),
    .waddr_q(waddr_q), .count_q(count_q), .busy(busy),
    .ev_accept(ev_accept), .ev_chk(ev_chk), .launch(launch), .launch_wr(launch_wr)
  );

  eep_buf #(.CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .h_we(hb_we), .h_idx(hb_idx), .h_wdata(host_wdata), .h_rdata(hb_rdata),
    .e_we(e_we), .e_widx(idx), .e_wdata(brx), .e_ridx(e_ridx), .e_rdata(e_rdata)
  );

  eep_spi_byte #(.HALF(HALF)) u_spi (
    .clk(clk), .rst_n(rst_n), .go(go_q), .tx(tx_q), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(bdone), .rx(brx)
  );

  assign spi_cs_n = cs_q;
  assign last     = (idx == cnt_lat - CNT_W'(1));
  assign e_ridx   = (st == SQ_ALO) ? '0 : idx + CNT_W'(1);
  assign e_we     = (st == SQ_DATA) && bdone && !wr_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      wr_lat   <= 1'b0;
      cnt_lat  <= '0;
      idx      <= '0;
      addr_lat <= '0;
      gap      <= '0;
      go_q     <= 1'b0;
      cs_q     <= 1'b1;
      tx_q     <= '0;
      seq_done <= 1'b0;
    end else begin
      go_q     <= 1'b0;
      seq_done <= 1'b0;
      case (st)
        SQ_IDLE: if (launch) begin
          wr_lat   <= launch_wr;
          cnt_lat  <= count_q;
          addr_lat <= word_to_byte(waddr_q);
          cs_q     <= 1'b0;
          go_q     <= 1'b1;
          tx_q     <= launch_wr ? OP_WREN : OP_READ;
          st       <= launch_wr ? SQ_WREN : SQ_INSTR;
        end
        SQ_WREN: if (bdone) begin
          cs_q <= 1'b1;
          gap  <= GW'(GAP - 1);
          st   <= SQ_GAP;
        end
        SQ_GAP: if (gap == '0) begin
          cs_q <= 1'b0;
          go_q <= 1'b1;
          tx_q <= OP_WRITE;
          st   <= SQ_INSTR;
        end else gap <= gap - GW'(1);
        SQ_INSTR: if (bdone) begin
          go_q <= 1'b1;
          tx_q <= addr_lat[15:8];
          st   <= SQ_AHI;
        end
        SQ_AHI: if (bdone) begin
          go_q <= 1'b1;
          tx_q <= addr_lat[7:0];
          st   <= SQ_ALO;
        end
        SQ_ALO: if (bdone) begin
          go_q <= 1'b1;
          tx_q <= wr_lat ? e_rdata : 8'h00;
          idx  <= '0;
          st   <= SQ_DATA;
        end
        SQ_DATA: if (bdone) begin
          if (last) begin
            cs_q <= 1'b1;
            gap  <= GW'(GAP - 1);
            st   <= SQ_TAIL;
          end else begin
            idx  <= idx + CNT_W'(1);
            go_q <= 1'b1;
            tx_q <= wr_lat ? e_rdata : 8'h00;
          end
        end
        SQ_TAIL: if (gap == '0) begin
          seq_done <= 1'b1;
          st       <= SQ_IDLE;
        end else gap <= gap - GW'(1);
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R10: serial clock idles low outside a frame
  a_r10_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R5: zero count produces no frame
  a_r5_zero_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_chk.cnt_zero) |=> spi_cs_n);
  // R6: a rejected start keeps the bus quiet and busy lasts one cycle
  a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_chk != '0) |=> (spi_cs_n && busy));
  a_r6_reject_short: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_chk != '0) |-> ##2 !busy);
  // R8: a clean start opens a frame
  a_r8_frame_open: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !spi_cs_n);
  // R11: busy only drops once chip select is released
  a_r11_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> spi_cs_n);
endmodule

// File: tb/sim_eep_xfer_ctl.sv
`timescale 1ns/1ps
module sim_eep_xfer_ctl;
  localparam int CNT_W = 3;
  localparam int DEPTH = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] host_addr = 8'h00;
  logic host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic if_en = 1'b1;
  logic dev_ack = 1'b1;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eep_xfer_ctl #(.CNT_W(CNT_W), .HALF(2), .GAP(3)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .if_en(if_en),
    .dev_ack(dev_ack), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // slave model
  int bitc = 0;
  int nfr = 0;
  int cs_falls = 0;
  int sck_idle = 0;
  int frag = 0;
  logic [7:0] fr [16];
  logic [7:0] lg [4][16];
  int lglen [4];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  always @(negedge spi_cs_n) begin
    bitc = 0;
    cs_falls++;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      fr[bitc / 8] = {fr[bitc / 8][6:0], spi_mosi};
      bitc++;
    end else sck_idle++;
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitc >= 24 && fr[0] == 8'h03) begin
      logic [7:0] d;
      d = pat(int'({fr[1], fr[2]}) + (bitc - 24) / 8);
      spi_miso = d[7 - (bitc % 8)];
    end
  end

  always @(posedge spi_cs_n) begin
    if (rst_n && nfr < 4) begin
      lglen[nfr] = bitc / 8;
      if (bitc % 8 != 0) frag++;
      for (int k = 0; k < 16; k++) lg[nfr][k] = fr[k];
      nfr++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [7:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    int n = 0;
    hrd(8'h1F, s);
    while (s[0] && n < 5000) begin
      @(negedge clk);
      hrd(8'h1F, s);
      n++;
    end
    chk(req, int'(n < 5000), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hrd(8'h1F, v); chk("R1 status reset", v, 8'h00);
    chk("R1 cs idle", spi_cs_n, 1);
    chk("R10 sck idle", spi_sck, 0);
    hrd(8'h28, v); chk("R2 waddr reset", v, 0);

    // R2 register access
    hwr(8'h28, 8'hA5); hrd(8'h28, v); chk("R2 waddr rw", v, 8'hA5);
    hwr(8'h29, 8'hFF); hrd(8'h29, v); chk("R2 count truncate", v, DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) hwr(8'(8'h40 + i), 8'(i * 13 + 1));
    for (int i = 0; i < DEPTH; i++) begin
      hrd(8'(8'h40 + i), v); chk("R2 buffer rw", v, (i * 13 + 1) & 255);
    end

    // R5/R6 start-time failures: m[2]=zero count, m[1]=no ack, m[0]=no enable
    for (int m = 1; m < 8; m++) begin
      hwr(8'h29, m[2] ? 8'd0 : 8'd3);
      dev_ack = !m[1]; if_en = !m[0];
      cs_falls = 0;
      hwr((m % 2 == 1) ? 8'h2B : 8'h2A, 8'h00);
      hrd(8'h1F, v); chk("R6 R3 flags with busy", v, (m << 1) | 1);
      @(negedge clk);
      hrd(8'h1F, v); chk("R6 R5 flags final busy low", v, m << 1);
      repeat (4) @(negedge clk);
      chk("R5 R6 no frame", cs_falls, 0);
      dev_ack = 1'b1; if_en = 1'b1;
    end

    // R8 read sweep, also R3/R4/R11
    for (int n = 1; n < DEPTH; n++) begin
      int wa;
      int ba;
      wa = (n == 1) ? 0 : (n == 2) ? 255 : (n == 3) ? 127 : (n == 4) ? 128 : (n * 37) & 255;
      ba = wa * 2;
      hwr(8'h28, 8'(wa)); hwr(8'h29, 8'(n));
      nfr = 0; frag = 0;
      hwr(8'h2A, 8'h00);
      hrd(8'h1F, v); chk("R3 busy first poll", v, 8'h01);
      wait_idle("R11 read completes");
      hrd(8'h1F, v); chk("R4 R11 status clean", v, 8'h00);
      chk("R11 cs released", spi_cs_n, 1);
      chk("R8 one frame", nfr, 1);
      chk("R8 frame length", lglen[0], n + 3);
      chk("R8 whole bytes", frag, 0);
      chk("R8 opcode", lg[0][0], 8'h03);
      chk("R8 addr hi", lg[0][1], ba >> 8);
      chk("R8 addr lo", lg[0][2], ba & 255);
      for (int i = 0; i < n; i++) begin
        hrd(8'(8'h40 + i), v); chk("R8 read data", v, pat(ba + i));
      end
    end

    // R9 write sweep
    for (int n = 1; n < DEPTH; n++) begin
      int wa;
      wa = (n * 71 + 128) & 255;
      for (int i = 0; i < DEPTH; i++) hwr(8'(8'h40 + i), 8'((n * 11 + i * 29) & 255));
      hwr(8'h28, 8'(wa)); hwr(8'h29, 8'(n));
      nfr = 0;
      hwr(8'h2B, 8'h00);
      hrd(8'h1F, v); chk("R3 busy first poll wr", v, 8'h01);
      wait_idle("R11 write completes");
      hrd(8'h1F, v); chk("R11 status clean wr", v, 8'h00);
      chk("R9 two frames", nfr, 2);
      chk("R9 enable frame len", lglen[0], 1);
      chk("R9 enable opcode", lg[0][0], 8'h06);
      chk("R9 write frame len", lglen[1], n + 3);
      chk("R9 write opcode", lg[1][0], 8'h02);
      chk("R9 addr hi", lg[1][1], (wa * 2) >> 8);
      chk("R9 addr lo", lg[1][2], (wa * 2) & 255);
      for (int i = 0; i < n; i++)
        chk("R9 write data", lg[1][3 + i], (n * 11 + i * 29) & 255);
    end

    // R7 writes ignored while busy
    hwr(8'h40, 8'h5C);
    hwr(8'h28, 8'h33); hwr(8'h29, 8'd2);
    nfr = 0;
    hwr(8'h2B, 8'h00);
    hwr(8'h28, 8'h11);
    hwr(8'h29, 8'd6);
    hwr(8'h40, 8'hEE);
    hwr(8'h2A, 8'h00);
    wait_idle("R7 op completes");
    hrd(8'h28, v); chk("R7 waddr kept", v, 8'h33);
    hrd(8'h29, v); chk("R7 count kept", v, 2);
    hrd(8'h40, v); chk("R7 buffer kept", v, 8'h5C);
    repeat (20) @(negedge clk);
    chk("R7 no retrigger", nfr, 2);
    chk("R7 data sent", lg[1][3], 8'h5C);
    chk("R7 length kept", lglen[1], 5);

    // R4 error replaced by next start
    dev_ack = 1'b0;
    hwr(8'h2A, 8'h00);
    @(negedge clk);
    hrd(8'h1F, v); chk("R6 ack error", v, 8'h04);
    dev_ack = 1'b1;
    hwr(8'h2A, 8'h00);
    hrd(8'h1F, v); chk("R4 flags cleared on start", v, 8'h01);
    wait_idle("R4 op completes");

    chk("R10 no sck while deselected", sck_idle, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule